// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transceiver

A full-duplex start/stop serial port for a host processor. The host writes a character into a one-deep transmit holding buffer. The transmitter frames it as a start bit, the data bits least significant first, an optional parity bit, and a stop interval. It then drives the frame on `txd`. The receiver watches `rxd` at sixteen samples per bit. It qualifies each start bit at its middle and samples every later bit at mid-bit. A finished character lands in a one-deep receive buffer that the host reads through the same data address.

The framing is chosen at run time through the mode register: 5 to 8 data bits, parity off, even or odd, and a stop interval of one, one and a half, or two bit times. The bit rate comes from a programmable divider. Three plain status pins (`tx_ready`, `tx_empty`, `rx_ready`) mirror the same bits of the status register.

The data write follows a valid/ready rule. A write to address 0 is the valid, and `tx_ready` is the ready. A write made while `tx_ready` is low is discarded; the host must hold the character until `tx_ready` is high. Received data has no back-pressure: a new character always replaces the buffered one, and an overrun is flagged.

Top module: `serial_xcvr`

## Requirements
- R1: After reset `txd` is 1, `tx_ready` and `tx_empty` are 1, and `rx_ready` is 0. A status read returns 0x03. The divider reads back its reset value `DEF_DIV`.
- R2: A transmitted frame is a low start bit, the data bits LSB first, an optional parity bit, then a high stop level. Each bit lasts 16*(divider+1) clock cycles, and the line is high while idle.
- R3: Mode bits [1:0] set the character length: 00=5, 01=6, 10=7, 11=8 data bits.
- R4: Mode bit [2] enables parity, and mode bit [3] picks odd (1) or even (0). The parity bit makes the count of ones over data plus parity odd or even accordingly.
- R5: Mode bits [5:4] set the stop interval: 00=1, 01=1.5, 1x=2 bit times. A character waiting in the buffer starts right at the end of the stop interval, so frame-to-frame spacing is exact.
- R6: `tx_ready` is high whenever the holding buffer is free. A data write (address 0) while `tx_ready` is low is dropped and never transmitted.
- R7: `tx_empty` is high only when the holding buffer is free and no frame is being shifted out.
- R8: The receiver requires the start bit to still be low at its mid-bit sample; a shorter low pulse is rejected and yields no character.
- R9: `rx_ready` rises when a character's stop bit has been sampled. A data read clears it. Characters shorter than 8 bits read right-aligned with zero upper bits.
- R10: Status bit 3 latches a parity mismatch and status bit 4 latches a low stop sample. A status read (address 1) clears both.
- R11: Status bit 5 latches when a character completes while `rx_ready` is still high. The buffer then holds the newer character. A status read clears the bit.
- R12: The divider is written low byte at address 2 and high byte at address 3, and reads back at the same addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects on this cycle) |
| reg_addr | input | 2 | 0 data, 1 mode (write) / status (read), 2 divider low, 3 divider high |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line (asynchronous) |
| tx_ready | output | 1 | Holding buffer can take a character |
| tx_empty | output | 1 | Transmitter fully idle |
| rx_ready | output | 1 | Received character waiting |

## Verification
The hardest case to reach from the ports is the exact stop length, above all the half-bit stop. A single frame only shows it as idle time, which no one can see. The bench therefore writes a second character as soon as `tx_ready` returns during the first frame. It then measures the cycles between the two start edges against the value computed from the mode. Overrun and a rejected start pulse are hard to reach too. The bench drives `rxd` itself, sending two frames without a read in between, and sending a low pulse shorter than half a bit. It then checks that a following valid frame still arrives intact.

// File: rtl/serial_pkg.sv
package serial_pkg;

  // Layout follows the mode register: [5:4] stop, [3] odd, [2] parity on, [1:0] length
  typedef struct packed {
    logic [1:0] stop;
    logic       odd;
    logic       par_en;
    logic [1:0] len;
  } frame_mode_t;

  localparam int OVERSAMPLE = 16;

  function automatic logic [3:0] data_bits(input logic [1:0] len);
    return 4'd5 + {2'b00, len};
  endfunction

  // Stop interval in oversample ticks
  function automatic logic [5:0] stop_ticks(input logic [1:0] code);
    case (code)
      2'b00:   return 6'd16;
      2'b01:   return 6'd24;
      default: return 6'd32;
    endcase
  endfunction

  function automatic logic [7:0] char_mask(input logic [1:0] len);
    return 8'hFF >> (4'd8 - data_bits(len));
  endfunction

endpackage

// File: rtl/serial_baud.sv
module serial_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = (cnt_q >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/serial_tx.sv
module serial_tx
  import serial_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  frame_mode_t mode,
  input  logic        wr_en,
  input  logic [7:0]  wr_data,
  output logic        txd,
  output logic        tx_ready,
  output logic        tx_empty
);
  typedef enum logic [2:0] {T_IDLE, T_START, T_DATA, T_PAR, T_STOP} tx_state_t;

  tx_state_t   state_q;
  frame_mode_t mode_q;
  logic [7:0]  hold_q, sh_q;
  logic        full_q, par_q;
  logic [5:0]  tcnt_q;
  logic [3:0]  bcnt_q;
  logic        stop_end, load;

  assign stop_end = (state_q == T_STOP) && (tcnt_q == stop_ticks(mode_q.stop) - 6'd1);
  assign load     = tick && full_q && ((state_q == T_IDLE) || stop_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= T_IDLE;
      mode_q  <= '0;
      hold_q  <= '0;
      sh_q    <= '0;
      full_q  <= 1'b0;
      par_q   <= 1'b0;
      tcnt_q  <= '0;
      bcnt_q  <= '0;
    end else begin
      if (wr_en && !full_q) begin
        hold_q <= wr_data;
        full_q <= 1'b1;
      end
      if (load) begin
        mode_q  <= mode;
        sh_q    <= hold_q & char_mask(mode.len);
        par_q   <= (^(hold_q & char_mask(mode.len))) ^ mode.odd;
        full_q  <= 1'b0;
        state_q <= T_START;
        tcnt_q  <= '0;
      end else if (tick) begin
        case (state_q)
          T_START: begin
            if (tcnt_q == 6'd15) begin
              state_q <= T_DATA;
              tcnt_q  <= '0;
              bcnt_q  <= '0;
            end else tcnt_q <= tcnt_q + 6'd1;
          end
          T_DATA: begin
            if (tcnt_q == 6'd15) begin
              tcnt_q <= '0;
              sh_q   <= {1'b0, sh_q[7:1]};
              if (bcnt_q == data_bits(mode_q.len) - 4'd1)
                state_q <= mode_q.par_en ? T_PAR : T_STOP;
              else
                bcnt_q <= bcnt_q + 4'd1;
            end else tcnt_q <= tcnt_q + 6'd1;
          end
          T_PAR: begin
            if (tcnt_q == 6'd15) begin
              state_q <= T_STOP;
              tcnt_q  <= '0;
            end else tcnt_q <= tcnt_q + 6'd1;
          end
          T_STOP: begin
            if (stop_end) state_q <= T_IDLE;
            else          tcnt_q  <= tcnt_q + 6'd1;
          end
          default: state_q <= T_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    case (state_q)
      T_START: txd = 1'b0;
      T_DATA:  txd = sh_q[0];
      T_PAR:   txd = par_q;
      default: txd = 1'b1;
    endcase
  end

  assign tx_ready = !full_q;
  assign tx_empty = !full_q && (state_q == T_IDLE);
endmodule

// File: rtl/serial_rx.sv
module serial_rx
  import serial_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  frame_mode_t mode,
  input  logic        rxd,
  input  logic        rd_data,
  input  logic        clr_err,
  output logic [7:0]  rx_data,
  output logic        rx_ready,
  output logic        perr,
  output logic        ferr,
  output logic        ovr,
  output logic        deliver
);
  typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP} rx_state_t;

  rx_state_t  state_q;
  logic       s1_q, s2_q;
  logic [3:0] cnt_q, bcnt_q;
  logic [7:0] sh_q;
  logic       acc_q, pbad_q;

  assign deliver = tick && (state_q == R_STOP) && (cnt_q == 4'd15);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= rxd;
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= R_IDLE;
      cnt_q   <= '0;
      bcnt_q  <= '0;
      sh_q    <= '0;
      acc_q   <= 1'b0;
      pbad_q  <= 1'b0;
    end else if (tick) begin
      case (state_q)
        R_IDLE: begin
          if (!s2_q) begin
            state_q <= R_START;
            cnt_q   <= '0;
          end
        end
        R_START: begin
          if (cnt_q == 4'd6) begin
            cnt_q <= '0;
            if (!s2_q) begin
              state_q <= R_DATA;
              bcnt_q  <= '0;
              sh_q    <= '0;
              acc_q   <= 1'b0;
              pbad_q  <= 1'b0;
            end else state_q <= R_IDLE;
          end else cnt_q <= cnt_q + 4'd1;
        end
        R_DATA: begin
          cnt_q <= cnt_q + 4'd1;
          if (cnt_q == 4'd15) begin
            sh_q  <= {s2_q, sh_q[7:1]};
            acc_q <= acc_q ^ s2_q;
            if (bcnt_q == data_bits(mode.len) - 4'd1)
              state_q <= mode.par_en ? R_PAR : R_STOP;
            else
              bcnt_q <= bcnt_q + 4'd1;
          end
        end
        R_PAR: begin
          cnt_q <= cnt_q + 4'd1;
          if (cnt_q == 4'd15) begin
            pbad_q  <= s2_q ^ acc_q ^ mode.odd;
            state_q <= R_STOP;
          end
        end
        R_STOP: begin
          cnt_q <= cnt_q + 4'd1;
          if (cnt_q == 4'd15) state_q <= R_IDLE;
        end
        default: state_q <= R_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      rx_ready <= 1'b0;
      perr     <= 1'b0;
      ferr     <= 1'b0;
      ovr      <= 1'b0;
    end else begin
      rx_ready <= deliver | (rx_ready & ~rd_data);
      perr     <= (perr & ~clr_err) | (deliver & pbad_q);
      ferr     <= (ferr & ~clr_err) | (deliver & ~s2_q);
      ovr      <= (ovr & ~clr_err) | (deliver & rx_ready & ~rd_data);
      if (deliver) rx_data <= sh_q >> (4'd8 - data_bits(mode.len));
    end
  end
endmodule

// File: rtl/serial_xcvr.sv
module serial_xcvr
  import serial_pkg::*;
#(
  parameter int DIV_W   = 16,
  parameter int DEF_DIV = 26
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       txd,
  input  logic       rxd,
  output logic       tx_ready,
  output logic       tx_empty,
  output logic       rx_ready
);
  localparam logic [1:0] A_DATA = 2'd0, A_MODE = 2'd1, A_DIVL = 2'd2, A_DIVH = 2'd3;
  localparam frame_mode_t MODE_RST = '{stop: 2'b00, odd: 1'b0, par_en: 1'b0, len: 2'b11};

  frame_mode_t      mode_q;
  logic [DIV_W-1:0] div_q;
  logic             tick, rx_deliver, rx_perr, rx_ferr, rx_ovr;
  logic [7:0]       rx_data, status;
  logic             wdata_unused;

  assign wdata_unused = ^reg_wdata[7:6];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RST;
      div_q  <= DIV_W'(DEF_DIV);
    end else if (reg_wr) begin
      case (reg_addr)
        A_MODE: mode_q <= frame_mode_t'(reg_wdata[5:0]);
        A_DIVL: div_q  <= {div_q[DIV_W-1:8], reg_wdata};
        A_DIVH: div_q  <= {reg_wdata[DIV_W-9:0], div_q[7:0]};
        default: ;
      endcase
    end
  end

  serial_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .div(div_q), .tick(tick)
  );

  serial_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode_q),
    .wr_en(reg_wr && reg_addr == A_DATA), .wr_data(reg_wdata),
    .txd(txd), .tx_ready(tx_ready), .tx_empty(tx_empty)
  );

  serial_rx u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode_q), .rxd(rxd),
    .rd_data(reg_rd && reg_addr == A_DATA), .clr_err(reg_rd && reg_addr == A_MODE),
    .rx_data(rx_data), .rx_ready(rx_ready), .perr(rx_perr), .ferr(rx_ferr),
    .ovr(rx_ovr), .deliver(rx_deliver)
  );

  assign status = {2'b00, rx_ovr, rx_ferr, rx_perr, rx_ready, tx_empty, tx_ready};

  always_comb begin
    case (reg_addr)
      A_DATA:  reg_rdata = rx_data;
      A_MODE:  reg_rdata = status;
      A_DIVL:  reg_rdata = div_q[7:0];
      default: reg_rdata = 8'(div_q >> 8);
    endcase
  end
endmodule

// File: rtl/serial_xcvr_chk.sv
module serial_xcvr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic [1:0] reg_addr,
  input logic       txd,
  input logic       tx_ready,
  input logic       tx_empty,
  input logic       rx_ready,
  input logic       deliver,
  input logic       ovr
);
  p_wr_takes_buffer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0 && tx_ready) |=> !tx_ready);

  p_empty_means_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> tx_ready);

  p_idle_line_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> txd);

  p_char_sets_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    deliver |=> rx_ready);

  p_read_clears_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 2'd0 && !deliver) |=> !rx_ready);

  p_overrun_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (deliver && rx_ready && !(reg_rd && reg_addr == 2'd0)) |=> ovr);
endmodule

bind serial_xcvr serial_xcvr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .txd(txd), .tx_ready(tx_ready), .tx_empty(tx_empty), .rx_ready(rx_ready),
  .deliver(rx_deliver), .ovr(rx_ovr)
);

// File: tb/test_serial_xcvr.sv
module test_serial_xcvr;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       txd, tx_ready, tx_empty, rx_ready;
  logic       rxd_b = 1'b1;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int bit_clks = 64;
  int m_len = 8, m_pen = 0, m_odd = 0;
  int exp_q[$];
  int frames_seen = 0, last_fall = 0, last_gap = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  serial_xcvr #(.DIV_W(16), .DEF_DIV(3)) i_serial_xcvr (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .txd(txd), .rxd(rxd_b),
    .tx_ready(tx_ready), .tx_empty(tx_empty), .rx_ready(rx_ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic set_mode(input int len, input int pen, input int odd, input int stop);
    bus_wr(2'd1, 8'((stop << 4) | (odd << 3) | (pen << 2) | (len - 5)));
    m_len = len; m_pen = pen; m_odd = odd;
  endtask

  task automatic send_tx(input int d);
    while (!tx_ready) @(negedge clk);
    exp_q.push_back(d & ((1 << m_len) - 1));
    bus_wr(2'd0, 8'(d));
  endtask

  task automatic wait_tx_done();
    while (exp_q.size() != 0 || !tx_empty) @(negedge clk);
    repeat (bit_clks) @(negedge clk);
  endtask

  // Scoreboard monitor: decodes txd independently and compares against the queue
  initial begin
    forever begin
      int data, p;
      @(negedge txd);
      if (frames_seen > 0) last_gap = cyc - last_fall;
      last_fall = cyc;
      frames_seen++;
      repeat (bit_clks / 2) @(negedge clk);
      chk(txd == 1'b0, "R2 start bit low", int'(txd), 0);
      data = 0;
      for (int i = 0; i < m_len; i++) begin
        repeat (bit_clks) @(negedge clk);
        if (txd) data |= (1 << i);
      end
      if (m_pen != 0) begin
        repeat (bit_clks) @(negedge clk);
        p = ($countones(data) + m_odd) & 1;
        chk(int'(txd) == p, "R4 parity bit", int'(txd), p);
      end
      repeat (bit_clks) @(negedge clk);
      chk(txd == 1'b1, "R2 stop level high", int'(txd), 1);
      if (exp_q.size() == 0) chk(1'b0, "R6 unexpected frame", data, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(data == e, "R3 transmitted data", data, e);
      end
    end
  end

  task automatic rx_frame(input int d, input int n, input int pen, input int odd,
                          input int badpar, input int badstop);
    int p;
    @(negedge clk);
    rxd_b = 1'b0;
    repeat (bit_clks) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      rxd_b = ((d >> i) & 1) != 0;
      repeat (bit_clks) @(negedge clk);
    end
    if (pen != 0) begin
      p = ($countones(d & ((1 << n) - 1)) + odd + badpar) & 1;
      rxd_b = (p != 0);
      repeat (bit_clks) @(negedge clk);
    end
    if (badstop != 0) begin
      rxd_b = 1'b0;
      repeat (bit_clks * 3 / 4) @(negedge clk);
      rxd_b = 1'b1;
      repeat (bit_clks / 4) @(negedge clk);
    end else begin
      rxd_b = 1'b1;
      repeat (bit_clks) @(negedge clk);
    end
    repeat (bit_clks * 2) @(negedge clk);
  endtask

  initial begin
    #(8 * 190000);
    chk(1'b0, "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    logic [7:0] r;
    int fs;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    chk(txd == 1'b1 && tx_ready && tx_empty && !rx_ready, "R1 reset pins",
        {txd, tx_ready, tx_empty, rx_ready}, 4'b1110);
    bus_rd(2'd1, r); chk(r == 8'h03, "R1 reset status", r, 8'h03);
    bus_rd(2'd2, r); chk(r == 8'd3, "R1 R12 divider reset value", r, 3);

    // R2 R5: 8 data, no parity, 1 stop, back-to-back
    set_mode(8, 0, 0, 0);
    send_tx(8'hA5);
    @(negedge clk);
    chk(!tx_empty, "R7 busy after write", int'(tx_empty), 0);
    send_tx(8'h3C);
    wait_tx_done();
    chk(last_gap == 9 * 64 + 64, "R5 one stop spacing", last_gap, 9 * 64 + 64);
    chk(tx_empty, "R7 empty when done", int'(tx_empty), 1);

    // R3 R4 R5: 5 data, even parity, 2 stop
    set_mode(5, 1, 0, 2);
    send_tx(8'h35);
    send_tx(8'h0B);
    wait_tx_done();
    chk(last_gap == 7 * 64 + 128, "R5 two stop spacing", last_gap, 7 * 64 + 128);

    // R3 R4 R5: 7 data, odd parity, 1.5 stop
    set_mode(7, 1, 1, 1);
    send_tx(8'h7E);
    send_tx(8'h41);
    wait_tx_done();
    chk(last_gap == 9 * 64 + 96, "R5 one and a half stop spacing", last_gap, 9 * 64 + 96);

    // R3: 6 data, no parity
    set_mode(6, 0, 0, 0);
    send_tx(8'hFF);
    wait_tx_done();

    // R6: write while buffer occupied is dropped
    set_mode(8, 0, 0, 0);
    fs = frames_seen;
    send_tx(8'h11);
    while (tx_empty || !tx_ready) @(negedge clk);
    send_tx(8'h22);
    @(negedge clk);
    chk(!tx_ready, "R6 ready low with buffer full", int'(tx_ready), 0);
    bus_wr(2'd0, 8'h33);
    wait_tx_done();
    repeat (bit_clks * 12) @(negedge clk);
    chk(frames_seen - fs == 2, "R6 dropped write not sent", frames_seen - fs, 2);

    // R12: slower divider
    bus_wr(2'd2, 8'd7);
    bus_wr(2'd3, 8'd0);
    bit_clks = 128;
    bus_rd(2'd2, r); chk(r == 8'd7, "R12 divider low readback", r, 7);
    bus_rd(2'd3, r); chk(r == 8'd0, "R12 divider high readback", r, 0);
    send_tx(8'h96);
    wait_tx_done();
    bus_wr(2'd2, 8'd3);
    bit_clks = 64;

    // R9: receive 8N1
    rx_frame(8'hC3, 8, 0, 0, 0, 0);
    chk(rx_ready, "R9 ready after character", int'(rx_ready), 1);
    bus_rd(2'd0, r); chk(r == 8'hC3, "R9 received data", r, 8'hC3);
    @(negedge clk);
    chk(!rx_ready, "R9 read clears ready", int'(rx_ready), 0);
    bus_rd(2'd1, r); chk(r[5:3] == 3'b000, "R10 no errors on clean frame", r[5:3], 0);

    // R9 R3: 6 bits even parity, right aligned
    set_mode(6, 1, 0, 0);
    rx_frame(8'h2A, 6, 1, 0, 0, 0);
    bus_rd(2'd0, r); chk(r == 8'h2A, "R9 short char right aligned", r, 8'h2A);
    bus_rd(2'd1, r); chk(r[3] == 1'b0, "R10 good parity no flag", r[3], 0);

    // R10: parity error latched, cleared by status read
    rx_frame(8'h15, 6, 1, 0, 1, 0);
    bus_rd(2'd1, r); chk(r[3] == 1'b1, "R10 parity error flag", r[3], 1);
    bus_rd(2'd1, r); chk(r[3] == 1'b0, "R10 status read clears parity flag", r[3], 0);
    bus_rd(2'd0, r);

    // R10: framing error
    set_mode(8, 0, 0, 0);
    rx_frame(8'h81, 8, 0, 0, 0, 1);
    repeat (bit_clks * 2) @(negedge clk);
    bus_rd(2'd1, r); chk(r[4] == 1'b1, "R10 framing error flag", r[4], 1);
    bus_rd(2'd1, r); chk(r[4] == 1'b0, "R10 status read clears framing flag", r[4], 0);
    bus_rd(2'd0, r);
    @(negedge clk);
    chk(!rx_ready, "R8 low stop tail not taken as start", int'(rx_ready), 0);

    // R8: short low pulse rejected, following frame intact
    @(negedge clk);
    rxd_b = 1'b0;
    repeat (16) @(negedge clk);
    rxd_b = 1'b1;
    repeat (bit_clks * 2) @(negedge clk);
    chk(!rx_ready, "R8 glitch rejected", int'(rx_ready), 0);
    rx_frame(8'h5A, 8, 0, 0, 0, 0);
    bus_rd(2'd0, r); chk(r == 8'h5A, "R8 frame after glitch", r, 8'h5A);

    // R11: overrun keeps newest character
    rx_frame(8'h12, 8, 0, 0, 0, 0);
    rx_frame(8'h34, 8, 0, 0, 0, 0);
    bus_rd(2'd1, r); chk(r[5] == 1'b1, "R11 overrun flag", r[5], 1);
    bus_rd(2'd0, r); chk(r == 8'h34, "R11 newest character kept", r, 8'h34);
    bus_rd(2'd1, r); chk(r[5] == 1'b0, "R11 status read clears overrun", r[5], 0);

    finish_run();
  end
endmodule